// File: doc/BRIEF.md
# Coulomb-Count Capacity Tracker

This block is the digital core of a rechargeable-battery capacity gauge. Upstream logic turns the sense-resistor voltage into single-cycle count pulses, each with a direction, and into periodic self-discharge ticks. The block keeps three counters from these events: the available-capacity counter, the discharge accumulator and the learned full capacity. The available-capacity counter rises with charge and falls with discharge and self-discharge. The discharge accumulator measures how far the battery has been drained. The learned full capacity is the reference that the available-capacity counter may not exceed.

The learned capacity starts at a programmed value. It is replaced by the discharge accumulator only after a discharge that qualifies. Such a discharge began near full, ran down to the first empty threshold, was not broken by a charge, lost little to self-discharge and ended warm. The valid-discharge flag must also be set. A two-step charge qualifier decides when a charge is real. A saturating counter records how many real charges have passed since the capacity was last learned. The near-full point is 15/16 of the learned capacity (L − L>>4).

A count pulse and a self-discharge tick in the same cycle: the tick is dropped. A charge-done input overrides every count in its cycle.

Top module: `cap_tracker`

## Requirements
- R1: While `rst` is high at a clock edge, `lmd_o` loads `pfc_i`. In the same cycle `nac_o`, `dcr_o`, `cpi_o`, `edv1_o`, `edvf_o` and `vdq_o` clear to 0.
- R2: A count pulse with `cnt_dir_i`=1 is a charge pulse. It raises `nac_o` by one only while `nac_o` is below a ceiling. The ceiling is `lmd_o`, or `lmd_o - (lmd_o>>4)` while `cold_i` is high.
- R3: A count pulse with `cnt_dir_i`=0 is a discharge pulse. A discharge pulse or a self-discharge tick lowers `nac_o` by one, stopping at 0. A discharge pulse always advances `dcr_o`. A self-discharge tick advances `dcr_o` only while `nac_o` is nonzero.
- R4: `dcr_o` saturates at its all-ones value. A discharge pulse that arrives while `nac_o >= lmd_o - (lmd_o>>4)` restarts `dcr_o` at 1.
- R5: `lmd_o` takes the value of `dcr_o` on the first valid charge after the first-threshold flag has latched. This happens only when all of the following hold:
  - the last discharge restart saw `nac_o` at or above the near-full point;
  - no valid charge came after that restart;
  - fewer self-discharge ticks than (restart value of `nac_o`)>>4 were counted;
  - `cold_i` was low when the flag latched;
  - `vdq_o` was set when the flag latched.
- R6: If a qualified transfer carries a value below `lmd_o - (lmd_o>>4)`, `lmd_o` becomes that floor instead.
- R7: A valid charge is the second consecutive charge pulse. A discharge pulse or `flt_tmo_i` in between restarts the count. A valid charge while `edv1_o` is set forces `nac_o` to 0.
- R8: `edv1_o` and `edvf_o` set on their trip inputs and stay set with the trip low. They clear on the next valid charge.
- R9: `done_i` sets `nac_o` equal to `lmd_o` and sets `vdq_o`.
- R10: `cpi_o` rises by one on each valid charge and saturates at all-ones. It clears when a qualified transfer updates `lmd_o`.
- R11: `ci_o` is high exactly when `cpi_o >= CI_LIMIT`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high initialisation |
| cnt_pulse_i | input | 1 | One count pulse per cycle high |
| cnt_dir_i | input | 1 | Direction of the count pulse: 1 charge, 0 discharge |
| self_dis_i | input | 1 | Self-discharge tick |
| cold_i | input | 1 | Temperature below 0 °C |
| edv1_trip_i | input | 1 | First end-of-discharge comparator |
| edvf_trip_i | input | 1 | Final end-of-discharge comparator |
| done_i | input | 1 | Charge complete |
| flt_tmo_i | input | 1 | Magnitude filter timeout, cancels a pending charge qualification |
| pfc_i | input | CNT_W | Programmed full count |
| nac_o | output | CNT_W | Available capacity |
| dcr_o | output | CNT_W | Discharge accumulator |
| lmd_o | output | CNT_W | Learned full capacity |
| cpi_o | output | CPI_W | Valid charges since last learn |
| edv1_o | output | 1 | First threshold latched |
| edvf_o | output | 1 | Final threshold latched |
| vdq_o | output | 1 | Valid-discharge flag |
| ci_o | output | 1 | Capacity inaccurate |

## Verification
The bench builds the tracker with `CNT_W`=8, `CPI_W`=4 and `CI_LIMIT`=5, and programs a full count of 200. With an 8-bit accumulator, saturation at 255 takes only a few hundred discharge pulses. A 4-bit inaccuracy counter reaches both its flag and its saturation at 15 within twenty charge sessions. A full count of 200 puts the near-full point at 188. That makes the restart window, the 15/16 floor on a short learn and the self-discharge budget of 12 ticks all small, exact numbers.

// File: rtl/cap_pkg.sv
`timescale 1ns/1ps
package cap_pkg;

    typedef enum logic [1:0] {
        CQ_IDLE  = 2'd0,
        CQ_ONE   = 2'd1,
        CQ_VALID = 2'd2
    } cq_state_e;

    typedef struct packed {
        logic chg;
        logic dis;
        logic sd;
    } cnt_evt_t;

    // near-full point: x - x/16
    function automatic logic [31:0] near_full(input logic [31:0] x);
        return x - (x >> 4);
    endfunction

endpackage

// File: rtl/cap_chg_qual.sv
`timescale 1ns/1ps
module cap_chg_qual
    import cap_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic chg_i,
    input  logic dis_i,
    input  logic tmo_i,
    output logic vc_o
);
    cq_state_e st_q, st_d;

    always_comb begin
        st_d = st_q;
        vc_o = 1'b0;
        if (dis_i || tmo_i) begin
            st_d = CQ_IDLE;
        end else if (chg_i) begin
            case (st_q)
                CQ_IDLE: st_d = CQ_ONE;
                CQ_ONE: begin
                    st_d = CQ_VALID;
                    vc_o = 1'b1;
                end
                default: st_d = CQ_VALID;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= CQ_IDLE;
        else     st_q <= st_d;
    end

    // R7
    vc_lands_valid_chk: assert property (@(posedge clk) disable iff (rst)
        vc_o |=> (st_q == CQ_VALID));
    // R7
    vc_once_chk: assert property (@(posedge clk) disable iff (rst)
        (st_q == CQ_VALID) |-> !vc_o);
endmodule

// File: rtl/cap_edv_latch.sv
`timescale 1ns/1ps
module cap_edv_latch #(
    parameter int N = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] trip_i,
    input  logic         clr_i,
    output logic [N-1:0] flag_o,
    output logic         first_set_o
);
    logic [N-1:0] flag_q;

    for (genvar g = 0; g < N; g++) begin : g_flag
        always_ff @(posedge clk) begin
            if (rst)            flag_q[g] <= 1'b0;
            else if (trip_i[g]) flag_q[g] <= 1'b1;
            else if (clr_i)     flag_q[g] <= 1'b0;
        end

        // R8
        flag_hold_chk: assert property (@(posedge clk) disable iff (rst)
            (flag_q[g] && !clr_i) |=> flag_q[g]);
    end

    assign flag_o      = flag_q;
    assign first_set_o = trip_i[0] & ~flag_q[0];
endmodule

// File: rtl/cap_learn_ctl.sv
`timescale 1ns/1ps
module cap_learn_ctl #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start_i,
    input  logic             sd_i,
    input  logic [CNT_W-1:0] nac_i,
    input  logic             cold_i,
    input  logic             vdq_i,
    input  logic             edv1_set_i,
    input  logic             vc_i,
    output logic             xfer_ok_o
);
    localparam logic [CNT_W-1:0] SD_MAX = {CNT_W{1'b1}};

    logic             act_q, ok_q;
    logic [CNT_W-1:0] base_q, sdc_q;
    logic             sd_budget_ok;

    assign sd_budget_ok = sdc_q < (base_q >> 4);

    always_ff @(posedge clk) begin
        if (rst) begin
            act_q  <= 1'b0;
            base_q <= '0;
            sdc_q  <= '0;
        end else if (start_i) begin
            act_q  <= 1'b1;
            base_q <= nac_i;
            sdc_q  <= '0;
        end else begin
            if (vc_i) act_q <= 1'b0;
            if (sd_i && act_q && sdc_q != SD_MAX) sdc_q <= sdc_q + CNT_W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (rst)             ok_q <= 1'b0;
        else if (vc_i)       ok_q <= 1'b0;
        else if (edv1_set_i) ok_q <= act_q & sd_budget_ok & ~cold_i & vdq_i;
    end

    assign xfer_ok_o = ok_q;

    // R5
    ok_only_at_edv1_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(ok_q) |-> $past(edv1_set_i));
endmodule

// File: rtl/cap_tracker.sv
`timescale 1ns/1ps
module cap_tracker
    import cap_pkg::*;
#(
    parameter int CNT_W    = 16,
    parameter int CPI_W    = 8,
    parameter int CI_LIMIT = 64
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cnt_pulse_i,
    input  logic             cnt_dir_i,
    input  logic             self_dis_i,
    input  logic             cold_i,
    input  logic             edv1_trip_i,
    input  logic             edvf_trip_i,
    input  logic             done_i,
    input  logic             flt_tmo_i,
    input  logic [CNT_W-1:0] pfc_i,
    output logic [CNT_W-1:0] nac_o,
    output logic [CNT_W-1:0] dcr_o,
    output logic [CNT_W-1:0] lmd_o,
    output logic [CPI_W-1:0] cpi_o,
    output logic             edv1_o,
    output logic             edvf_o,
    output logic             vdq_o,
    output logic             ci_o
);
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};
    localparam logic [CPI_W-1:0] CPI_MAX = {CPI_W{1'b1}};
    localparam logic [CPI_W-1:0] CI_LIM  = CPI_W'(CI_LIMIT);

    logic [CNT_W-1:0] nac_q, dcr_q, lmd_q, nac_d, dcr_d, lmd_d;
    logic [CPI_W-1:0] cpi_q, cpi_d;
    logic             vdq_q;
    logic [CNT_W-1:0] nf_pt, ceil_v;
    cnt_evt_t         ev;
    logic             start, sd_eff, vc, learn, xfer_ok, edv1_set;
    logic [1:0]       edv_flags;

    assign nf_pt  = CNT_W'(near_full(32'(lmd_q)));
    assign ceil_v = cold_i ? nf_pt : lmd_q;

    assign ev.chg = cnt_pulse_i &  cnt_dir_i & ~done_i;
    assign ev.dis = cnt_pulse_i & ~cnt_dir_i & ~done_i;
    assign ev.sd  = self_dis_i  & ~cnt_pulse_i & ~done_i;

    assign start  = ev.dis & (nac_q >= nf_pt);
    assign sd_eff = ev.sd & (nac_q != '0);
    assign learn  = vc & edv_flags[0];

    cap_chg_qual u_qual (
        .clk   (clk),
        .rst   (rst),
        .chg_i (ev.chg),
        .dis_i (ev.dis),
        .tmo_i (flt_tmo_i),
        .vc_o  (vc)
    );

    cap_edv_latch #(.N(2)) u_edv (
        .clk         (clk),
        .rst         (rst),
        .trip_i      ({edvf_trip_i, edv1_trip_i}),
        .clr_i       (vc),
        .flag_o      (edv_flags),
        .first_set_o (edv1_set)
    );

    cap_learn_ctl #(.CNT_W(CNT_W)) u_learn (
        .clk        (clk),
        .rst        (rst),
        .start_i    (start),
        .sd_i       (sd_eff),
        .nac_i      (nac_q),
        .cold_i     (cold_i),
        .vdq_i      (vdq_q),
        .edv1_set_i (edv1_set),
        .vc_i       (vc),
        .xfer_ok_o  (xfer_ok)
    );

    always_comb begin
        nac_d = nac_q;
        if (done_i)                                     nac_d = lmd_q;
        else if (learn)                                 nac_d = '0;
        else if (ev.chg && nac_q < ceil_v)              nac_d = nac_q + CNT_W'(1);
        else if ((ev.dis || ev.sd) && nac_q != '0)      nac_d = nac_q - CNT_W'(1);

        dcr_d = dcr_q;
        if (start)                                      dcr_d = CNT_W'(1);
        else if ((ev.dis || sd_eff) && dcr_q != CNT_MAX) dcr_d = dcr_q + CNT_W'(1);

        lmd_d = lmd_q;
        if (learn && xfer_ok)                           lmd_d = (dcr_q < nf_pt) ? nf_pt : dcr_q;

        cpi_d = cpi_q;
        if (learn && xfer_ok)                           cpi_d = '0;
        else if (vc && cpi_q != CPI_MAX)                cpi_d = cpi_q + CPI_W'(1);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            nac_q <= '0;
            dcr_q <= '0;
            lmd_q <= pfc_i;
            cpi_q <= '0;
            vdq_q <= 1'b0;
        end else begin
            nac_q <= nac_d;
            dcr_q <= dcr_d;
            lmd_q <= lmd_d;
            cpi_q <= cpi_d;
            if (done_i)     vdq_q <= 1'b1;
            else if (learn) vdq_q <= 1'b0;
        end
    end

    assign nac_o  = nac_q;
    assign dcr_o  = dcr_q;
    assign lmd_o  = lmd_q;
    assign cpi_o  = cpi_q;
    assign edv1_o = edv_flags[0];
    assign edvf_o = edv_flags[1];
    assign vdq_o  = vdq_q;
    assign ci_o   = cpi_q >= CI_LIM;

    // R2
    nac_le_lmd_chk: assert property (@(posedge clk) disable iff (rst)
        nac_q <= lmd_q);
    // R5
    lmd_only_on_learn_chk: assert property (@(posedge clk) disable iff (rst)
        !learn |=> $stable(lmd_q));
    // R4
    dcr_no_wrap_chk: assert property (@(posedge clk) disable iff (rst)
        (dcr_q == CNT_MAX && !start) |=> (dcr_q == CNT_MAX));
    // R10
    cpi_no_wrap_chk: assert property (@(posedge clk) disable iff (rst)
        (cpi_q == CPI_MAX && !(learn && xfer_ok)) |=> (cpi_q == CPI_MAX));
endmodule

// File: tb/test_cap_tracker.sv
`timescale 1ns/1ps
module test_cap_tracker;
    localparam int CW = 8;
    localparam int PW = 4;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic cnt_pulse = 0, cnt_dir = 0, self_dis = 0, cold = 0;
    logic edv1_trip = 0, edvf_trip = 0, done = 0, flt_tmo = 0;
    logic [CW-1:0] pfc = 8'd200;
    logic [CW-1:0] nac, dcr, lmd;
    logic [PW-1:0] cpi;
    logic edv1, edvf, vdq, ci;

    int n_chk = 0, n_bad = 0;
    bit finished = 0;

    always #2 clk = ~clk;

    cap_tracker #(.CNT_W(CW), .CPI_W(PW), .CI_LIMIT(5)) i_cap_tracker (
        .clk(clk), .rst(rst), .cnt_pulse_i(cnt_pulse), .cnt_dir_i(cnt_dir),
        .self_dis_i(self_dis), .cold_i(cold), .edv1_trip_i(edv1_trip),
        .edvf_trip_i(edvf_trip), .done_i(done), .flt_tmo_i(flt_tmo),
        .pfc_i(pfc), .nac_o(nac), .dcr_o(dcr), .lmd_o(lmd), .cpi_o(cpi),
        .edv1_o(edv1), .edvf_o(edvf), .vdq_o(vdq), .ci_o(ci)
    );

    task automatic chk(string req, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk); rst = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic chg(int n);
        @(negedge clk); cnt_pulse = 1; cnt_dir = 1;
        repeat (n) @(negedge clk);
        cnt_pulse = 0;
    endtask

    task automatic dis(int n);
        @(negedge clk); cnt_pulse = 1; cnt_dir = 0;
        repeat (n) @(negedge clk);
        cnt_pulse = 0;
    endtask

    task automatic sdt(int n);
        @(negedge clk); self_dis = 1;
        repeat (n) @(negedge clk);
        self_dis = 0;
    endtask

    task automatic tmo();
        @(negedge clk); flt_tmo = 1; @(negedge clk); flt_tmo = 0;
    endtask

    task automatic done_p();
        @(negedge clk); done = 1; @(negedge clk); done = 0;
    endtask

    task automatic trip1(bit c);
        @(negedge clk); edv1_trip = 1; cold = c;
        @(negedge clk); edv1_trip = 0; cold = 0;
    endtask

    task automatic t_reset();
        pfc = 8'd100; do_reset();
        chk("R1 lmd", lmd, 100);
        pfc = 8'd200; do_reset();
        chk("R1 lmd", lmd, 200); chk("R1 nac", nac, 0); chk("R1 dcr", dcr, 0);
        chk("R1 cpi", cpi, 0); chk("R1 flags", {edv1, edvf, vdq, ci}, 0);
    endtask

    task automatic t_clamp();
        do_reset(); chg(210);
        chk("R2 nac clamp", nac, 200); chk("R10 cpi one session", cpi, 1);
        do_reset(); @(negedge clk); cold = 1; chg(210); cold = 0;
        chk("R2 cold clamp", nac, 188);
    endtask

    task automatic t_learn();
        do_reset(); chg(2);
        chk("R10 cpi", cpi, 1);
        done_p();
        chk("R9 nac", nac, 200); chk("R9 vdq", vdq, 1);
        dis(150);
        chk("R4 dcr restart", dcr, 138); chk("R3 nac", nac, 50);
        dis(60);
        chk("R3 nac floor", nac, 0); chk("R3 dcr", dcr, 198);
        trip1(0); repeat (3) @(negedge clk);
        chk("R8 edv1 held", edv1, 1);
        chg(1);
        chk("R7 first charge", nac, 1);
        chg(1);
        chk("R5 lmd learned", lmd, 198); chk("R7 nac cleared", nac, 0);
        chk("R10 cpi cleared", cpi, 0); chk("R8 edv1 cleared", edv1, 0);
    endtask

    task automatic t_floor();
        do_reset(); done_p(); dis(100);
        chk("R4 dcr", dcr, 88);
        trip1(0); chg(2);
        chk("R6 lmd floor", lmd, 188); chk("R7 nac cleared", nac, 0);
    endtask

    task automatic t_cold_edv();
        do_reset(); done_p(); dis(100); trip1(1); chg(2);
        chk("R5 cold blocks", lmd, 200); chk("R7 nac cleared", nac, 0);
        chk("R10 cpi inc", cpi, 1);
    endtask

    task automatic t_selfdis();
        do_reset(); done_p(); dis(1); sdt(12);
        chk("R3 sd dcr", dcr, 13); chk("R3 sd nac", nac, 187);
        dis(50); trip1(0); chg(2);
        chk("R5 sd budget blocks", lmd, 200);
    endtask

    task automatic t_empty();
        do_reset(); sdt(1);
        chk("R3 sd at zero", dcr, 0);
        dis(1);
        chk("R3 dis at zero", dcr, 1); chk("R3 nac", nac, 0);
        dis(300);
        chk("R4 dcr sat", dcr, 255);
    endtask

    task automatic t_qual();
        do_reset(); chg(1); tmo(); chg(1);
        chk("R7 timeout", cpi, 0);
        chg(1);
        chk("R7 valid", cpi, 1);
        dis(1); chg(1);
        chk("R7 discharge breaks", cpi, 1);
        chg(1);
        chk("R7 valid again", cpi, 2); chk("R2 nac", nac, 4);
    endtask

    task automatic t_cpi();
        do_reset();
        for (int i = 1; i <= 20; i++) begin
            chg(2); tmo();
            if (i == 4) chk("R11 ci low", ci, 0);
            if (i == 5) chk("R11 ci high", ci, 1);
        end
        chk("R10 cpi sat", cpi, 15); chk("R11 ci", ci, 1);
    endtask

    task automatic t_edvf();
        do_reset();
        @(negedge clk); edvf_trip = 1; @(negedge clk); edvf_trip = 0;
        repeat (3) @(negedge clk);
        chk("R8 edvf held", edvf, 1);
        chg(1);
        chk("R8 edvf kept", edvf, 1);
        chg(1);
        chk("R8 edvf cleared", edvf, 0);
    endtask

    initial begin
        t_reset(); t_clamp(); t_learn(); t_floor(); t_cold_edv();
        t_selfdis(); t_empty(); t_qual(); t_cpi(); t_edvf();
        finished = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        #(4 * 200000);
        if (!finished) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual hung expected done");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end
endmodule